// File: doc/BRIEF.md
# Two-Dimensional Repeated-Block DMA Address Generator

This block produces the source and destination addresses that a DMA data mover follows through a two-dimensional transfer. One block is a run of bytes that is carried in bursts. The whole block is carried a programmed number of times. After each burst, each side jumps by its own signed burst offset, counted from the byte just past the end of that burst. After the last burst of a block, each side jumps by its own signed block offset instead. With an offset of zero, the next burst or block follows on directly from the previous one.

Software supplies the base addresses, the block size, the burst size, the repeat count and four offsets, then pulses `start`. The block copies the whole configuration at that moment. It presents the address pair for the current burst and raises `burst_start` for one cycle. The data mover pulses `step` once for each burst it finishes. The block then either moves to the next burst or, after the final burst of the final block, pulses `done` and returns to idle. The block moves no data itself.

Top module: `dma2d_rpt_agen`

## Requirements
- R1: A `start` pulse while `busy` is low latches the configuration and loads `src_addr`/`dst_addr` with the two base addresses. One cycle later `busy` is 1 and `burst_start` is 1. A `start` pulse while `busy` is high is ignored: the addresses do not change and no strobe appears.
- R2: Each burst carries min(burst size, bytes left in the current block) bytes. The last burst of a block may be shorter than the burst size.
- R3: After a burst that is not the last of its block, each side's next address is its current address plus the burst length plus that side's signed burst offset (14-bit two's complement), taken modulo 2^32.
- R4: After the last burst of a block that is not the final block, each side's next address is its current address plus the burst length plus that side's signed block offset (17-bit two's complement), modulo 2^32. `blk_end` pulses for one cycle at that point.
- R5: With all offsets zero, the bursts and blocks follow on contiguously, so the addresses advance by exactly the burst lengths.
- R6: The field `rpt_m1` holds the block count minus one. A value of 0 to 2047 gives 1 to 2048 block repetitions.
- R7: After the final burst of the final block, `done` and `blk_end` pulse together for one cycle and `busy` falls. No offset is applied: the addresses keep the start address of the final burst.
- R8: `burst_start` is a one-cycle pulse in the cycle after `start` or after each non-final `step`, and is low in every other cycle. A `step` while idle has no effect.
- R9: The addresses stay unchanged in every cycle that neither starts a transfer nor advances a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer with the configuration present on the inputs |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| blk_bytes | input | LW | Block size in bytes (at least 1) |
| burst_bytes | input | LW | Burst size in bytes (at least 1) |
| rpt_m1 | input | RW | Block repetitions minus one |
| src_burst_ofs | input | BOW | Signed source jump after each inner burst |
| dst_burst_ofs | input | BOW | Signed destination jump after each inner burst |
| src_blk_ofs | input | KOW | Signed source jump after each block |
| dst_blk_ofs | input | KOW | Signed destination jump after each block |
| step | input | 1 | Data mover has finished the current burst |
| src_addr | output | AW | Current burst source address |
| dst_addr | output | AW | Current burst destination address |
| busy | output | 1 | A transfer is in progress |
| burst_start | output | 1 | One-cycle strobe: a new burst's addresses are valid |
| blk_end | output | 1 | One-cycle pulse: a block has just completed |
| done | output | 1 | One-cycle pulse: the whole transfer has completed |

## Verification
The directed cases cover the following faults:

- **Shortened final burst.** A block size that is not a multiple of the burst size forces a shorter final burst in each block. A design that always adds the full burst size would then land every following block at the wrong place.
- **Offset selection.** Source and destination take offsets of opposite signs, and negative offsets run the address below zero so that it must wrap. A design that swapped the burst offset and the block offset, or used only one side's offsets, would give the wrong addresses after the first block. So would one that extended the offsets without their sign.
- **Start and end of a transfer.** A single-burst block exercises the case where no burst offset is ever used. The maximum repeat count of 2048 is run in full. After `done`, the cases check that no extra offset was applied. They also pulse `start` and `step` at moments when each must be ignored; an off-by-one block counter or an unguarded load would show up here.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [0:0] {
    LANE_SRC = 1'b0,
    LANE_DST = 1'b1
  } lane_e;

  localparam int NUM_LANES = 2;
endpackage

// File: rtl/dma2d_seq.sv
module dma2d_seq #(
  parameter int LW = 16,
  parameter int RW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic [LW-1:0] blk_bytes,
  input  logic [LW-1:0] burst_bytes,
  input  logic [RW-1:0] rpt_m1,
  output logic          load_ev,
  output logic          adv_ev,
  output logic          fin_ev,
  output logic          last_burst,
  output logic [LW-1:0] cur_len,
  output logic          busy,
  output logic          burst_start,
  output logic          blk_end,
  output logic          done
);
  logic [LW-1:0] blk_q, bur_q, remain;
  logic [RW-1:0] blk_left;
  logic          last_blk;

  // burst length: whatever is smaller, the burst size or the bytes left
  function automatic logic [LW-1:0] burst_len(input logic [LW-1:0] left,
                                              input logic [LW-1:0] bur);
    return (left < bur) ? left : bur;
  endfunction

  assign load_ev    = start & ~busy;
  assign adv_ev     = step & busy;
  assign cur_len    = burst_len(remain, bur_q);
  assign last_burst = (remain <= bur_q);
  assign last_blk   = (blk_left == '0);
  assign fin_ev     = adv_ev & last_burst & last_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q       <= '0;
      bur_q       <= '0;
      remain      <= '0;
      blk_left    <= '0;
      busy        <= 1'b0;
      burst_start <= 1'b0;
      blk_end     <= 1'b0;
      done        <= 1'b0;
    end else begin
      burst_start <= load_ev | (adv_ev & ~fin_ev);
      blk_end     <= adv_ev & last_burst;
      done        <= fin_ev;
      if (load_ev) begin
        blk_q    <= blk_bytes;
        bur_q    <= burst_bytes;
        remain   <= blk_bytes;
        blk_left <= rpt_m1;
        busy     <= 1'b1;
      end else if (adv_ev) begin
        if (fin_ev) begin
          busy <= 1'b0;
        end else if (last_burst) begin
          remain   <= blk_q;
          blk_left <= blk_left - 1'b1;
        end else begin
          remain <= remain - cur_len;
        end
      end
    end
  end

  AST_DONE_WITH_BLKEND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> blk_end); // R7
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_STROBE_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_start && done)); // R8
  AST_IDLE_STEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!burst_start && !blk_end && !done)); // R8
  AST_BLKEND_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !done) |-> (busy && burst_start)); // R4
endmodule

// File: rtl/dma2d_lane.sv
module dma2d_lane #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int BOW = 14,
  parameter int KOW = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_ev,
  input  logic                  adv_ev,
  input  logic                  fin_ev,
  input  logic                  last_burst,
  input  logic [LW-1:0]         cur_len,
  input  logic [AW-1:0]         base,
  input  logic signed [BOW-1:0] burst_ofs,
  input  logic signed [KOW-1:0] blk_ofs,
  output logic [AW-1:0]         addr
);
  logic signed [BOW-1:0] burst_ofs_q;
  logic signed [KOW-1:0] blk_ofs_q;
  logic [AW-1:0]         jump;
  logic                  move_ev;

  function automatic logic [AW-1:0] ext_burst(input logic signed [BOW-1:0] v);
    return {{(AW-BOW){v[BOW-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] ext_blk(input logic signed [KOW-1:0] v);
    return {{(AW-KOW){v[KOW-1]}}, v};
  endfunction

  // next address: end of the burst just done, plus the selected jump
  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                              input logic [LW-1:0] len,
                                              input logic [AW-1:0] j);
    return a + {{(AW-LW){1'b0}}, len} + j;
  endfunction

  assign jump    = last_burst ? ext_blk(blk_ofs_q) : ext_burst(burst_ofs_q);
  assign move_ev = adv_ev & ~fin_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr        <= '0;
      burst_ofs_q <= '0;
      blk_ofs_q   <= '0;
    end else if (load_ev) begin
      addr        <= base;
      burst_ofs_q <= burst_ofs;
      blk_ofs_q   <= blk_ofs;
    end else if (move_ev) begin
      addr <= next_addr(addr, cur_len, jump);
    end
  end

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !move_ev) |=> $stable(addr)); // R9
  AST_LANE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (addr == $past(base))); // R1
endmodule

// File: rtl/dma2d_rpt_agen.sv
module dma2d_rpt_agen #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int RW  = 11,
  parameter int BOW = 14,
  parameter int KOW = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [AW-1:0]         src_base,
  input  logic [AW-1:0]         dst_base,
  input  logic [LW-1:0]         blk_bytes,
  input  logic [LW-1:0]         burst_bytes,
  input  logic [RW-1:0]         rpt_m1,
  input  logic signed [BOW-1:0] src_burst_ofs,
  input  logic signed [BOW-1:0] dst_burst_ofs,
  input  logic signed [KOW-1:0] src_blk_ofs,
  input  logic signed [KOW-1:0] dst_blk_ofs,
  input  logic                  step,
  output logic [AW-1:0]         src_addr,
  output logic [AW-1:0]         dst_addr,
  output logic                  busy,
  output logic                  burst_start,
  output logic                  blk_end,
  output logic                  done
);
  import dma2d_pkg::*;

  logic          load_ev, adv_ev, fin_ev, last_burst;
  logic [LW-1:0] cur_len;

  logic [AW-1:0]         base_a  [NUM_LANES];
  logic signed [BOW-1:0] bofs_a  [NUM_LANES];
  logic signed [KOW-1:0] kofs_a  [NUM_LANES];
  logic [AW-1:0]         addr_a  [NUM_LANES];

  assign base_a[LANE_SRC] = src_base;
  assign base_a[LANE_DST] = dst_base;
  assign bofs_a[LANE_SRC] = src_burst_ofs;
  assign bofs_a[LANE_DST] = dst_burst_ofs;
  assign kofs_a[LANE_SRC] = src_blk_ofs;
  assign kofs_a[LANE_DST] = dst_blk_ofs;
  assign src_addr = addr_a[LANE_SRC];
  assign dst_addr = addr_a[LANE_DST];

  dma2d_seq #(.LW(LW), .RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .blk_bytes(blk_bytes), .burst_bytes(burst_bytes), .rpt_m1(rpt_m1),
    .load_ev(load_ev), .adv_ev(adv_ev), .fin_ev(fin_ev),
    .last_burst(last_burst), .cur_len(cur_len), .busy(busy),
    .burst_start(burst_start), .blk_end(blk_end), .done(done)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dma2d_lane #(.AW(AW), .LW(LW), .BOW(BOW), .KOW(KOW)) u_lane (
      .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .adv_ev(adv_ev),
      .fin_ev(fin_ev), .last_burst(last_burst), .cur_len(cur_len),
      .base(base_a[g]), .burst_ofs(bofs_a[g]), .blk_ofs(kofs_a[g]),
      .addr(addr_a[g])
    );
  end

  AST_FINAL_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev |=> ($stable(src_addr) && $stable(dst_addr))); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step) |=> ($stable(src_addr) && !burst_start)); // R1
endmodule

// File: tb/dma2d_rpt_agen_test.sv
module dma2d_rpt_agen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        step = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [15:0] blk_bytes = '0, burst_bytes = '0;
  logic [10:0] rpt_m1 = '0;
  logic signed [13:0] src_burst_ofs = '0, dst_burst_ofs = '0;
  logic signed [16:0] src_blk_ofs = '0, dst_blk_ofs = '0;
  logic [31:0] src_addr, dst_addr;
  logic        busy, burst_start, blk_end, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2d_rpt_agen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
    .dst_base(dst_base), .blk_bytes(blk_bytes), .burst_bytes(burst_bytes),
    .rpt_m1(rpt_m1), .src_burst_ofs(src_burst_ofs), .dst_burst_ofs(dst_burst_ofs),
    .src_blk_ofs(src_blk_ofs), .dst_blk_ofs(dst_blk_ofs), .step(step),
    .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy),
    .burst_start(burst_start), .blk_end(blk_end), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Runs one full transfer against a model built from the requirements.
  task automatic run_case(input logic [31:0] sb, input logic [31:0] db,
                          input int blk, input int bur, input int cnt,
                          input int sbo, input int dbo, input int sko, input int dko,
                          input bit gap, input bit poke);
    logic [31:0] es, ed;
    src_base = sb; dst_base = db; blk_bytes = 16'(blk); burst_bytes = 16'(bur);
    rpt_m1 = 11'(cnt - 1);
    src_burst_ofs = 14'(sbo); dst_burst_ofs = 14'(dbo);
    src_blk_ofs = 17'(sko); dst_blk_ofs = 17'(dko);
    start = 1'b1;
    tick();
    start = 1'b0;
    es = sb; ed = db;
    chk("R1 busy after start", 32'(busy), 32'd1);
    chk("R1 first strobe", 32'(burst_start), 32'd1);
    chk("R1 src base", src_addr, es);
    chk("R1 dst base", dst_addr, ed);
    for (int k = 0; k < cnt; k++) begin
      int rem = blk;
      while (rem > 0) begin
        int  len;
        bit  last, finalb;
        len = (rem < bur) ? rem : bur;   // R2
        last = (len == rem);
        finalb = last && (k == cnt - 1);
        if (gap) begin
          if (poke) begin
            src_base = ~sb; dst_base = ~db;
            start = 1'b1;
          end
          tick();
          start = 1'b0;
          chk("R8 strobe low in idle cycle", 32'(burst_start), 32'd0);
          chk("R9 src held", src_addr, es);
          chk("R9 dst held", dst_addr, ed);
          if (poke) chk("R1 start ignored while busy", 32'(busy), 32'd1);
        end
        step = 1'b1;
        tick();
        step = 1'b0;
        chk("R4 blk_end", 32'(blk_end), 32'(last));
        chk("R7 done", 32'(done), 32'(finalb));
        if (finalb) begin
          chk("R7 busy falls", 32'(busy), 32'd0);
          chk("R7 src no final jump", src_addr, es);
          chk("R7 dst no final jump", dst_addr, ed);
          chk("R8 no strobe after final", 32'(burst_start), 32'd0);
        end else begin
          es = es + 32'(len) + (last ? 32'(sko) : 32'(sbo));  // R3 / R4
          ed = ed + 32'(len) + (last ? 32'(dko) : 32'(dbo));
          chk(last ? "R4 src block jump" : "R3 src burst jump", src_addr, es);
          chk(last ? "R4 dst block jump" : "R3 dst burst jump", dst_addr, ed);
          chk("R8 strobe after step", 32'(burst_start), 32'd1);
        end
        rem -= len;
      end
    end
    // idle step has no effect
    step = 1'b1;
    tick();
    step = 1'b0;
    chk("R8 idle step src", src_addr, es);
    chk("R8 idle step dst", dst_addr, ed);
    chk("R8 idle step no strobe", 32'(burst_start | blk_end | done | busy), 32'd0);
    tick();
  endtask

  task automatic t_reset();
    chk("R9 reset src", src_addr, 32'd0);
    chk("R9 reset dst", dst_addr, 32'd0);
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R8 reset strobe", 32'(burst_start | blk_end | done), 32'd0);
  endtask

  // R5: zero offsets, contiguous walk, partial last burst
  task automatic t_contiguous();
    run_case(32'h0000_1000, 32'h0002_0000, 10, 4, 3, 0, 0, 0, 0, 1'b0, 1'b0);
  endtask

  // R3 R4: mixed-sign offsets, gaps between steps, start poked while busy
  task automatic t_offsets();
    run_case(32'h4000_0000, 32'h8000_0100, 12, 4, 3, 8191, -8191, 65535, -65535, 1'b1, 1'b1);
  endtask

  // R3: negative offsets wrap below zero
  task automatic t_wrap();
    run_case(32'h0000_0010, 32'hFFFF_FFF0, 6, 2, 2, -40, 20, -100, 7, 1'b0, 1'b0);
  endtask

  // R2 R7: burst larger than block; single block
  task automatic t_single_burst();
    run_case(32'h0000_0200, 32'h0000_0300, 5, 8, 4, 1000, 1000, -3, 3, 1'b1, 1'b0);
    run_case(32'h0000_0A00, 32'h0000_0B00, 8, 8, 1, 5, 5, 9, 9, 1'b0, 1'b0);
  endtask

  // R6: maximum repeat count 2048
  task automatic t_max_repeat();
    run_case(32'h1000_0000, 32'h2000_0000, 2, 1, 2048, 3, -1, 16, -16, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_contiguous();
    t_offsets();
    t_wrap();
    t_single_burst();
    t_max_repeat();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule